// File: doc/BRIEF.md
# GPIB Auxiliary Command Local-Message Unit

This block sits behind the host register port of a GPIB talker/listener. It decodes host writes to the auxiliary command register and keeps the local messages they control: the power-on hold, a one-cycle chip reset, return-to-local and request-service. It also keeps the status bits of the serial-poll path that the host reads back.

The host writes an 8-bit command to address 5. The low three bits pick the message and bit 3 carries the value the message takes. The upper nibble must be zero. Three status registers can be read combinationally on the same port:
- address 1 holds the byte-out flag.
- address 2 holds the sticky status-byte-sent interrupt.
- address 3 holds the service-request pending flag, the serial-poll-active flag and the local messages.

The serial-poll logic reports three conditions: affirmative poll response, status-byte transmit and serial-poll active. A status byte counts as transferred only in a cycle where all three are true.

The block enters the power-on hold at reset. The host must release it before any other message can be set.

Top module: `aux_local_msg`

## Requirements
- R1: After rst_ni is deasserted, pon_o is 1, rtl_o, rsv_o, srq_o and chip_reset_o are 0, addresses 1 and 2 read 00H, and address 3 reads 01H (bit 0 = pon).
- R2: Writing 00H to address 5 sets the power-on hold and 08H releases it. While the hold is set, rtl, rsv, the pending-service flag, the status-sent interrupt and the byte-out flag are held at 0, set commands for rtl and rsv are lost, and address 3 bit 5 (serial-poll active) reads 0 whatever spas_i is.
- R3: Writing 02H to address 5 clears rtl, rsv, the pending-service flag (address 3 bit 6), the status-sent interrupt (address 2 bit 4) and the byte-out flag (address 1 bit 1) at the next edge. It leaves the hold unchanged and pulses chip_reset_o high for exactly the following cycle.
- R4: A 00H write followed by a 02H write leaves address 1 bit 1 (byte-out) reading 0, even when bo_set_i was pulsed just before.
- R5: Writing 0DH to address 5 sets rtl (address 3 bit 2, rtl_o) and 05H clears it. The value holds until the next such command.
- R6: Writing 0BH to address 5 sets rsv (address 3 bit 1, rsv_o) and the pending-service flag (address 3 bit 6, srq_o). Writing 03H clears both.
- R7: In the cycle after a status byte transfer (aprs_i, strs_i and spas_i all 1), the pending-service flag is 0. rsv is unchanged.
- R8: The status-sent interrupt (address 2 bit 4) is set by a status byte transfer and by nothing else. Any two of the three transfer conditions without the third leave it at 0.
- R9: The status-sent interrupt is sticky and is cleared by a read of address 2. If a transfer falls in the same cycle as that read, the read returns the old value and the bit is set afterwards.
- R10: The byte-out flag (address 1 bit 1) is set by bo_set_i and cleared by a read of address 1. If both happen in the same cycle, the read returns the old value and the flag is set afterwards.
- R11: The following writes change no local message: writes to any address other than 5, writes with a nonzero upper nibble, and writes whose low three bits are 001, 100, 110 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears read-sensitive bits) |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i while rd_en_i is high |
| bo_set_i | input | 1 | Data-out register became empty |
| aprs_i | input | 1 | Affirmative poll response condition |
| strs_i | input | 1 | Status byte transmit condition |
| spas_i | input | 1 | Serial poll active condition |
| pon_o | output | 1 | Power-on hold local message |
| rtl_o | output | 1 | Return-to-local local message |
| rsv_o | output | 1 | Request-service local message |
| srq_o | output | 1 | Service request pending |
| chip_reset_o | output | 1 | One-cycle chip reset pulse |

## Verification
Two collisions are exercised. In the first, a status byte transfer is driven in the same cycle as a read of address 2. The read data must show the interrupt still clear, and a second read must find it set and then clear it. The byte-out flag gets the same treatment, with bo_set_i raised during a read of address 1. A third case raises the three transfer conditions two at a time around a pending request, and the interrupt and pending flag must stay untouched until all three coincide.

// File: rtl/aux_msg_pkg.sv
package aux_msg_pkg;

  localparam int unsigned SEL_W   = 3;
  localparam int unsigned VAL_BIT = 3;
  localparam int unsigned OPC_W   = VAL_BIT + 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_PON   = 3'b000,
    SEL_RESET = 3'b010,
    SEL_RSV   = 3'b011,
    SEL_RTL   = 3'b101
  } aux_sel_e;

  typedef struct packed {
    logic pon_set;
    logic pon_clr;
    logic reset;
    logic rsv_wr;
    logic rtl_wr;
    logic val;
  } aux_cmd_t;

endpackage

// File: rtl/aux_cmd_decode.sv
module aux_cmd_decode
  import aux_msg_pkg::*;
#(
  parameter int unsigned AW       = 3,
  parameter int unsigned DW       = 8,
  parameter int unsigned AUX_ADDR = 5
) (
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output aux_cmd_t      cmd_o
);

  logic             hit;
  logic [SEL_W-1:0] sel;

  assign hit = wr_en_i && (addr_i == AW'(AUX_ADDR))
               && (wdata_i[DW-1:OPC_W] == '0);
  assign sel = wdata_i[SEL_W-1:0];

  always_comb begin
    cmd_o     = '0;
    cmd_o.val = wdata_i[VAL_BIT];
    if (hit) begin
      unique case (sel)
        SEL_PON: begin
          cmd_o.pon_set = !wdata_i[VAL_BIT];
          cmd_o.pon_clr = wdata_i[VAL_BIT];
        end
        SEL_RESET: cmd_o.reset  = 1'b1;
        SEL_RSV:   cmd_o.rsv_wr = 1'b1;
        SEL_RTL:   cmd_o.rtl_wr = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/local_msg_regs.sv
module local_msg_regs
  import aux_msg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  aux_cmd_t cmd_i,
  output logic     pon_o,
  output logic     rtl_o,
  output logic     rsv_o,
  output logic     chip_reset_o
);

  logic pon_q, rtl_q, rsv_q, rst_pulse_q;
  logic wipe;

  // the hold and the reset both force messages inactive
  assign wipe = pon_q || cmd_i.pon_set || cmd_i.reset;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pon_q       <= 1'b1;
      rtl_q       <= 1'b0;
      rsv_q       <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      rst_pulse_q <= cmd_i.reset;
      if (cmd_i.pon_set)      pon_q <= 1'b1;
      else if (cmd_i.pon_clr) pon_q <= 1'b0;
      if (wipe)               rtl_q <= 1'b0;
      else if (cmd_i.rtl_wr)  rtl_q <= cmd_i.val;
      if (wipe)               rsv_q <= 1'b0;
      else if (cmd_i.rsv_wr)  rsv_q <= cmd_i.val;
    end
  end

  assign pon_o        = pon_q;
  assign rtl_o        = rtl_q;
  assign rsv_o        = rsv_q;
  assign chip_reset_o = rst_pulse_q;

endmodule

// File: rtl/spoll_status.sv
module spoll_status
  import aux_msg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  aux_cmd_t cmd_i,
  input  logic     pon_i,
  input  logic     aprs_i,
  input  logic     strs_i,
  input  logic     spas_i,
  input  logic     bo_set_i,
  input  logic     rd_isr1_i,
  input  logic     rd_isr2_i,
  output logic     srqs_o,
  output logic     spasc_o,
  output logic     bo_o,
  output logic     spas_vis_o
);

  logic srqs_q, spasc_q, bo_q;
  logic wipe, xfer;

  assign wipe = pon_i || cmd_i.pon_set || cmd_i.reset;
  assign xfer = aprs_i && strs_i && spas_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srqs_q  <= 1'b0;
      spasc_q <= 1'b0;
      bo_q    <= 1'b0;
    end else begin
      // a host command beats a transfer in the same cycle
      if (wipe)              srqs_q <= 1'b0;
      else if (cmd_i.rsv_wr) srqs_q <= cmd_i.val;
      else if (xfer)         srqs_q <= 1'b0;
      // set beats read-clear
      if (wipe)              spasc_q <= 1'b0;
      else if (xfer)         spasc_q <= 1'b1;
      else if (rd_isr2_i)    spasc_q <= 1'b0;
      if (wipe)              bo_q <= 1'b0;
      else if (bo_set_i)     bo_q <= 1'b1;
      else if (rd_isr1_i)    bo_q <= 1'b0;
    end
  end

  assign srqs_o     = srqs_q;
  assign spasc_o    = spasc_q;
  assign bo_o       = bo_q;
  assign spas_vis_o = spas_i && !pon_i;

endmodule

// File: rtl/aux_local_msg.sv
module aux_local_msg
  import aux_msg_pkg::*;
#(
  parameter int unsigned AW        = 3,
  parameter int unsigned DW        = 8,
  parameter int unsigned AUX_ADDR  = 5,
  parameter int unsigned ISR1_ADDR = 1,
  parameter int unsigned ISR2_ADDR = 2,
  parameter int unsigned SPS_ADDR  = 3,
  parameter int unsigned BO_BIT    = 1,
  parameter int unsigned SPASC_BIT = 4,
  parameter int unsigned PON_BIT   = 0,
  parameter int unsigned RSV_BIT   = 1,
  parameter int unsigned RTL_BIT   = 2,
  parameter int unsigned SPAS_BIT  = 5,
  parameter int unsigned SRQS_BIT  = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          bo_set_i,
  input  logic          aprs_i,
  input  logic          strs_i,
  input  logic          spas_i,
  output logic          pon_o,
  output logic          rtl_o,
  output logic          rsv_o,
  output logic          srq_o,
  output logic          chip_reset_o
);

  aux_cmd_t cmd;
  logic     rd_isr1, rd_isr2;
  logic     srqs, spasc_q, bo, spas_vis;

  assign rd_isr1 = rd_en_i && (addr_i == AW'(ISR1_ADDR));
  assign rd_isr2 = rd_en_i && (addr_i == AW'(ISR2_ADDR));

  aux_cmd_decode #(.AW(AW), .DW(DW), .AUX_ADDR(AUX_ADDR)) u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cmd_o   (cmd)
  );

  local_msg_regs u_msg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd),
    .pon_o        (pon_o),
    .rtl_o        (rtl_o),
    .rsv_o        (rsv_o),
    .chip_reset_o (chip_reset_o)
  );

  spoll_status u_sps (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .pon_i      (pon_o),
    .aprs_i     (aprs_i),
    .strs_i     (strs_i),
    .spas_i     (spas_i),
    .bo_set_i   (bo_set_i),
    .rd_isr1_i  (rd_isr1),
    .rd_isr2_i  (rd_isr2),
    .srqs_o     (srqs),
    .spasc_o    (spasc_q),
    .bo_o       (bo),
    .spas_vis_o (spas_vis)
  );

  assign srq_o = srqs;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == AW'(ISR1_ADDR)) rdata_o[BO_BIT] = bo;
      if (addr_i == AW'(ISR2_ADDR)) rdata_o[SPASC_BIT] = spasc_q;
      if (addr_i == AW'(SPS_ADDR)) begin
        rdata_o[PON_BIT]  = pon_o;
        rdata_o[RSV_BIT]  = rsv_o;
        rdata_o[RTL_BIT]  = rtl_o;
        rdata_o[SPAS_BIT] = spas_vis;
        rdata_o[SRQS_BIT] = srqs;
      end
    end
  end

endmodule

// File: rtl/aux_local_msg_chk.sv
module aux_local_msg_chk #(
  parameter int unsigned AW       = 3,
  parameter int unsigned DW       = 8,
  parameter int unsigned AUX_ADDR = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          aprs_i,
  input logic          strs_i,
  input logic          spas_i,
  input logic          pon_o,
  input logic          rtl_o,
  input logic          rsv_o,
  input logic          srq_o,
  input logic          chip_reset_o,
  input logic          spasc_q
);

  logic aux_wr, xfer;
  assign aux_wr = wr_en_i && (addr_i == AW'(AUX_ADDR));
  assign xfer   = aprs_i && strs_i && spas_i;

  a_r2_pon_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pon_o |-> (!rtl_o && !rsv_o && !srq_o && !spasc_q));

  a_r3_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_wr && wdata_i == DW'(8'h02)) |=>
      (!rtl_o && !rsv_o && !srq_o && !spasc_q && chip_reset_o));

  a_r5_rtl_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_wr && wdata_i == DW'(8'h0D) && !pon_o) |=> rtl_o);

  a_r5_rtl_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_wr && wdata_i == DW'(8'h05)) |=> !rtl_o);

  a_r7_srq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srq_o && xfer && !aux_wr) |=> !srq_o);

  a_r8_spasc_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spasc_q) |-> $past(xfer));

  a_r11_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_wr && wdata_i[DW-1:4] != '0) |=>
      ($stable(rtl_o) && $stable(rsv_o) && $stable(pon_o)));

endmodule

bind aux_local_msg aux_local_msg_chk #(.AW(AW), .DW(DW), .AUX_ADDR(AUX_ADDR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .aprs_i       (aprs_i),
  .strs_i       (strs_i),
  .spas_i       (spas_i),
  .pon_o        (pon_o),
  .rtl_o        (rtl_o),
  .rsv_o        (rsv_o),
  .srq_o        (srq_o),
  .chip_reset_o (chip_reset_o),
  .spasc_q      (spasc_q)
);

// File: tb/tb_aux_local_msg.sv
`timescale 1ns/1ps
module tb_aux_local_msg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       bo_set = 1'b0, aprs = 1'b0, strs = 1'b0, spas = 1'b0;
  logic       pon, rtl, rsv, srq, crst;

  always #10 clk = ~clk;

  aux_local_msg dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .bo_set_i(bo_set),
    .aprs_i(aprs), .strs_i(strs), .spas_i(spas), .pon_o(pon), .rtl_o(rtl),
    .rsv_o(rsv), .srq_o(srq), .chip_reset_o(crst)
  );

  typedef struct {
    string      req;
    logic [7:0] rd;
    logic [4:0] fl; // {pon, rtl, rsv, srq, chip_reset}
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  // monitor
  initial forever begin
    @(negedge clk);
    #5;
    while (sb_q.size() > 0) begin
      exp_t e;
      logic [4:0] act;
      e   = sb_q.pop_front();
      act = {pon, rtl, rsv, srq, crst};
      n_chk++;
      if (rdata !== e.rd || act !== e.fl) begin
        n_bad++;
        $display("FAIL %s: rdata=%h flags=%b expected rdata=%h flags=%b",
                 e.req, rdata, act, e.rd, e.fl);
      end
    end
  end

  task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                      input logic r, input logic b, input logic ap,
                      input logic st, input logic sp, input bit chk,
                      input string req, input logic [7:0] erd,
                      input logic [4:0] efl);
    exp_t e;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; rd_en = r;
    bo_set = b; aprs = ap; strs = st; spas = sp;
    if (chk) begin
      e.req = req; e.rd = erd; e.fl = efl;
      sb_q.push_back(e);
    end
    @(posedge clk);
  endtask

  task automatic wr5(input logic [7:0] d);
    step(1, 3'd5, d, 0, 0, 0, 0, 0, 0, "", 8'h00, 5'b0);
  endtask

  task automatic wr_at(input logic [2:0] a, input logic [7:0] d);
    step(1, a, d, 0, 0, 0, 0, 0, 0, "", 8'h00, 5'b0);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a,
                        input logic [7:0] erd, input logic [4:0] efl);
    step(0, a, 8'h00, 1, 0, 0, 0, 0, 1, req, erd, efl);
  endtask

  task automatic drive(input logic b, input logic ap, input logic st, input logic sp);
    step(0, 3'd0, 8'h00, 0, b, ap, st, sp, 0, "", 8'h00, 5'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 sps", 3'd3, 8'h01, 5'b10000);
    rd_chk("R1 isr1", 3'd1, 8'h00, 5'b10000);
    rd_chk("R1 isr2", 3'd2, 8'h00, 5'b10000);

    // R2 hold blocks sets
    drive(1, 0, 0, 0);
    wr5(8'h0D);
    wr5(8'h0B);
    rd_chk("R2 bo held", 3'd1, 8'h00, 5'b10000);
    step(0, 3'd3, 8'h00, 1, 0, 0, 0, 1, 1, "R2 spas masked", 8'h01, 5'b10000);
    wr5(8'h08);
    rd_chk("R2 release", 3'd3, 8'h00, 5'b00000);

    // R5 rtl set/clear
    wr5(8'h0D);
    rd_chk("R5 set", 3'd3, 8'h04, 5'b01000);
    wr5(8'h05);
    rd_chk("R5 clr", 3'd3, 8'h00, 5'b00000);

    // R11 ignored writes
    wr5(8'h0D);
    wr5(8'h15);
    wr5(8'h8B);
    wr_at(3'd4, 8'h05);
    wr_at(3'd3, 8'h0B);
    wr5(8'h01);
    wr5(8'h0C);
    wr5(8'h06);
    wr5(8'h0F);
    rd_chk("R11 ignored", 3'd3, 8'h04, 5'b01000);

    // R6 rsv set
    wr5(8'h0B);
    rd_chk("R6 set", 3'd3, 8'h46, 5'b01110);

    // R8 partial transfers
    drive(0, 1, 1, 0);
    drive(0, 1, 0, 1);
    drive(0, 0, 1, 1);
    rd_chk("R8 partial isr2", 3'd2, 8'h00, 5'b01110);
    rd_chk("R8 partial sps", 3'd3, 8'h46, 5'b01110);

    // R7 full transfer
    drive(0, 1, 1, 1);
    rd_chk("R7 srq drop", 3'd3, 8'h06, 5'b01100);
    rd_chk("R8 set", 3'd2, 8'h10, 5'b01100);
    rd_chk("R9 read clear", 3'd2, 8'h00, 5'b01100);

    // R9 collision: transfer during read of isr2
    step(0, 3'd2, 8'h00, 1, 0, 1, 1, 1, 1, "R9 collide old", 8'h00, 5'b01100);
    rd_chk("R9 set wins", 3'd2, 8'h10, 5'b01100);
    rd_chk("R9 cleared", 3'd2, 8'h00, 5'b01100);

    // R6 rsv clear
    wr5(8'h0B);
    wr5(8'h03);
    rd_chk("R6 clr", 3'd3, 8'h04, 5'b01000);

    // R10 byte-out flag
    drive(1, 0, 0, 0);
    rd_chk("R10 set", 3'd1, 8'h02, 5'b01000);
    rd_chk("R10 read clear", 3'd1, 8'h00, 5'b01000);
    step(0, 3'd1, 8'h00, 1, 1, 0, 0, 0, 1, "R10 collide old", 8'h00, 5'b01000);
    rd_chk("R10 set wins", 3'd1, 8'h02, 5'b01000);

    // R3 chip reset
    drive(0, 1, 1, 1);
    wr5(8'h0B);
    drive(1, 0, 0, 0);
    rd_chk("R6 pre-reset", 3'd3, 8'h46, 5'b01110);
    wr5(8'h02);
    rd_chk("R3 msgs+pulse", 3'd3, 8'h00, 5'b00001);
    rd_chk("R3 isr2", 3'd2, 8'h00, 5'b00000);
    rd_chk("R3 isr1", 3'd1, 8'h00, 5'b00000);

    // R4 pon then reset
    wr5(8'h0D);
    drive(1, 0, 0, 0);
    wr5(8'h00);
    wr5(8'h02);
    rd_chk("R4 bo clear", 3'd1, 8'h00, 5'b10001);
    rd_chk("R2 pon wiped rtl", 3'd3, 8'h01, 5'b10000);

    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule